// File: doc/BRIEF.md
# External Memory Bus Cycle Generator

This block converts simple internal read and write requests into the waveforms an external parallel memory expects. It drives one chip select, an address bus, a read strobe and a write strobe. Write data goes out on a data-out bus with an output enable, and read data comes back on a data-in bus. The block runs on a clock at twice the bus rate. Each bus cycle therefore has a first-half tick and a second-half tick, and every strobe edge that falls mid-cycle is still a synchronous register-timed event.

Two read protocols can be chosen at run time. In the standard protocol the read strobe waits for the second half of the first bus cycle, as the write strobe always does. In the early protocol the read strobe falls with chip select, and it stays low across back-to-back reads. In that mode a read that directly follows a write gets one idle turnaround bus cycle first. A configuration port sets the protocol, wait-state enable and wait-state count. A boot-width input, sampled while reset is held, selects an 8-bit or 16-bit data bus.

The requester holds `req_valid` and its fields until `req_ready` pulses. A new request may be presented in the tick right after the pulse, which gives back-to-back bus cycles.

Top module: `ebus_cycle_gen`

## Requirements
- R1: After reset the block uses the standard protocol with wait states enabled and a count of 7. Every access then lasts 9 bus cycles (18 ticks). All memory strobes and chip select are high, `mem_doe` is 0 and `req_ready` is 0.
- R2: In the standard protocol, `mem_cs_n` is low and `mem_addr` holds the request address from the first tick of a read. `mem_rd_n` is high in that first tick and low from the second tick to the end of the access.
- R3: For a write, in either protocol, `mem_we_n` is high in the first tick and low from the second tick to the end. `mem_doe` is 1 exactly while `mem_we_n` is low, and `mem_dout` then carries the write data.
- R4: In the early protocol, `mem_rd_n` is low from the first tick of a read (the first tick after any turnaround).
- R5: In the early protocol, two reads presented back to back keep `mem_rd_n` low with no high tick between them.
- R6: In the early protocol, a read presented in the tick right after a write's `req_ready` first gets one turnaround bus cycle (2 ticks). During it `mem_cs_n`, `mem_rd_n` and `mem_we_n` are all high. The turnaround adds to the programmed wait states.
- R7: An access with wait states disabled lasts one bus cycle (2 ticks). With wait states enabled and count N, it lasts N+2 bus cycles.
- R8: A configuration write applies to the next access that starts after it.
- R9: `boot_wide`=1 sampled during reset selects a 16-bit bus. With 0, the upper byte of `rsp_rdata` is 0 and the upper byte of `mem_dout` is driven 0.
- R10: `req_ready` is a one-tick pulse in the last tick of an access. For a read, `rsp_rdata` takes `mem_din` at the end of that tick.
- R11: A write presented right after a standard-protocol read starts at once, with `mem_cs_n` low in its first tick and no turnaround.
- R12: `mem_rd_n` and `mem_we_n` are never low together, and `mem_doe` is never 1 while `mem_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus cycle rate |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_wide | input | 1 | Bus width select, sampled while reset is low (1 = 16-bit) |
| cfg_wr | input | 1 | Loads the three configuration fields below |
| cfg_early | input | 1 | Protocol: 0 standard, 1 early read |
| cfg_wse | input | 1 | Wait-state enable |
| cfg_nws | input | NWS_W | Wait-state count N (N+1 extra bus cycles) |
| req_valid | input | 1 | Request pending, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Pulse in the last tick of the access |
| rsp_rdata | output | DW | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_addr | output | AW | Memory address |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout | output | DW | Write data to memory |
| mem_doe | output | 1 | Output enable for `mem_dout` |
| mem_din | input | DW | Read data from memory |

## Verification
The bench goes after the tick where the read strobe first falls under each protocol. A design that mixed up the protocols would show a high strobe where a low one is due, or the reverse, in the first tick of the access. It chains early reads to catch a strobe that rises between them. It puts a read right after a write in both protocols: a missing turnaround, or one that also appears in standard mode or after a standard read, shows up as an access that is two ticks off. It changes the wait-state count, then resets into the narrow bus, which exposes a stale configuration, a wrong cycle count or an unmasked upper byte.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic {
    PROT_STD   = 1'b0,
    PROT_EARLY = 1'b1
  } rd_prot_e;

  // Index of the final tick of an access, counted from 0 at its first tick.
  // Bus cycles: optional turnaround, one base cycle, optional N+1 waits.
  function automatic int last_tick(input bit turn, input bit wse, input int nws);
    int cycles;
    cycles = (turn ? 1 : 0) + 1 + (wse ? nws + 1 : 0);
    return 2 * cycles - 1;
  endfunction

endpackage

// File: rtl/ebus_cfg_regs.sv
module ebus_cfg_regs
  import ebus_pkg::*;
#(
  parameter int NWS_W   = 3,
  parameter int NWS_RST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_wide,
  input  logic             wr,
  input  logic             early_in,
  input  logic             wse_in,
  input  logic [NWS_W-1:0] nws_in,
  output rd_prot_e         prot,
  output logic             wse,
  output logic [NWS_W-1:0] nws,
  output logic             wide
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot <= PROT_STD;
      wse  <= 1'b1;
      nws  <= NWS_W'(NWS_RST);
    end else if (wr) begin
      prot <= early_in ? PROT_EARLY : PROT_STD;
      wse  <= wse_in;
      nws  <= nws_in;
    end
  end

  // Width strap: captured on every clock while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) wide <= boot_wide;
  end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int NWS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  rd_prot_e         prot,
  input  logic             wse,
  input  logic [NWS_W-1:0] nws,
  output logic             req_ready,
  output logic             busy,
  output logic             active,
  output logic             cur_write,
  output logic             cur_early,
  output logic             in_turn,
  output logic             acc_first,
  output logic [AW-1:0]    cur_addr,
  output logic [DW-1:0]    cur_wdata
);

  localparam int CW = NWS_W + 3;

  logic          busy_q, turn_q, wr_q, early_q, last_wr_q;
  logic [CW-1:0] tcnt_q, last_q, cur_tcnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          start, need_turn, cur_turn;

  assign start     = !busy_q && req_valid;
  assign need_turn = (prot == PROT_EARLY) && last_wr_q && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      turn_q    <= 1'b0;
      wr_q      <= 1'b0;
      early_q   <= 1'b0;
      last_wr_q <= 1'b0;
      tcnt_q    <= '0;
      last_q    <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      tcnt_q  <= CW'(1);
      turn_q  <= need_turn;
      wr_q    <= req_write;
      early_q <= (prot == PROT_EARLY);
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      last_q  <= CW'(last_tick(need_turn, wse, int'(nws)));
    end else if (busy_q) begin
      if (tcnt_q == last_q) begin
        busy_q    <= 1'b0;
        last_wr_q <= wr_q;
      end else begin
        tcnt_q <= tcnt_q + CW'(1);
      end
    end else begin
      last_wr_q <= 1'b0;
    end
  end

  // The first tick of an access is driven straight from the request
  assign active    = busy_q || req_valid;
  assign busy      = busy_q;
  assign cur_write = busy_q ? wr_q    : req_write;
  assign cur_early = busy_q ? early_q : (prot == PROT_EARLY);
  assign cur_turn  = busy_q ? turn_q  : need_turn;
  assign cur_tcnt  = busy_q ? tcnt_q  : '0;
  assign cur_addr  = busy_q ? addr_q  : req_addr;
  assign cur_wdata = wdata_q;
  assign in_turn   = active && cur_turn && (cur_tcnt < CW'(2));
  assign acc_first = active && !in_turn && (cur_tcnt == (cur_turn ? CW'(2) : CW'(0)));
  assign req_ready = busy_q && (tcnt_q == last_q);

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> busy_q && !start);

endmodule

// File: rtl/ebus_pins.sv
module ebus_pins #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          active,
  input  logic          cur_write,
  input  logic          cur_early,
  input  logic          in_turn,
  input  logic          acc_first,
  input  logic          req_ready,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_wdata,
  input  logic [DW-1:0] mem_din,
  output logic          mem_cs_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  output logic [DW-1:0] rsp_rdata
);

  localparam int NB = 8;

  logic          drive, rd_low, we_low;
  logic [DW-1:0] lane_mask;

  assign lane_mask = wide ? {DW{1'b1}} : {{(DW-NB){1'b0}}, {NB{1'b1}}};

  assign drive  = active && !in_turn;
  assign rd_low = drive && !cur_write && (cur_early || !acc_first);
  assign we_low = drive && cur_write && !acc_first;

  assign mem_cs_n = !drive;
  assign mem_addr = cur_addr;
  assign mem_rd_n = !rd_low;
  assign mem_we_n = !we_low;
  assign mem_doe  = we_low;
  assign mem_dout = we_low ? (cur_wdata & lane_mask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                      rsp_rdata <= '0;
    else if (req_ready && !cur_write) rsp_rdata <= mem_din & lane_mask;
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_we_n));

  // R12
  doe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> !mem_cs_n);

endmodule

// File: rtl/ebus_cycle_gen.sv
module ebus_cycle_gen
  import ebus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int NWS_W   = 3,
  parameter int NWS_RST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_wide,
  input  logic             cfg_wr,
  input  logic             cfg_early,
  input  logic             cfg_wse,
  input  logic [NWS_W-1:0] cfg_nws,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic             mem_cs_n,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd_n,
  output logic             mem_we_n,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_doe,
  input  logic [DW-1:0]    mem_din
);

  rd_prot_e         prot;
  logic             wse, wide;
  logic [NWS_W-1:0] nws;
  logic             busy, active, cur_write, cur_early, in_turn, acc_first;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    cur_wdata;

  ebus_cfg_regs #(.NWS_W(NWS_W), .NWS_RST(NWS_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .boot_wide(boot_wide), .wr(cfg_wr),
    .early_in(cfg_early), .wse_in(cfg_wse), .nws_in(cfg_nws),
    .prot(prot), .wse(wse), .nws(nws), .wide(wide)
  );

  ebus_seq #(.AW(AW), .DW(DW), .NWS_W(NWS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .prot(prot), .wse(wse), .nws(nws),
    .req_ready(req_ready), .busy(busy), .active(active), .cur_write(cur_write),
    .cur_early(cur_early), .in_turn(in_turn), .acc_first(acc_first),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  ebus_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .wide(wide), .active(active), .cur_write(cur_write),
    .cur_early(cur_early), .in_turn(in_turn), .acc_first(acc_first),
    .req_ready(req_ready), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .mem_din(mem_din), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
    .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .rsp_rdata(rsp_rdata)
  );

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(mem_addr));

  // R2
  std_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_first && !cur_early) |-> mem_rd_n);

  // R6
  turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |-> (mem_cs_n && mem_rd_n && mem_we_n));

  // R10
  ready_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_cs_n);

endmodule

// File: tb/ebus_cycle_gen_test.sv
`timescale 1ns/1ps
module ebus_cycle_gen_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NWS_W = 3;

  typedef struct {
    bit          wr;
    bit          turn;
    bit          early;
    logic [15:0] data;
    int          ticks;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_wide = 1'b1;
  logic cfg_wr = 1'b0, cfg_early = 1'b0, cfg_wse = 1'b0;
  logic [NWS_W-1:0] cfg_nws = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, mem_cs_n, mem_rd_n, mem_we_n, mem_doe;
  logic [DW-1:0] rsp_rdata, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  item_t q[$];

  // bench-side model state
  bit m_early = 0, m_wse = 1, m_prevwr = 0, m_wide = 1;
  int m_nws = 7;

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_model(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'h3C};
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] d);
    return m_wide ? d : {8'h00, d[7:0]};
  endfunction

  assign mem_din = mem_model(mem_addr);

  ebus_cycle_gen #(.AW(AW), .DW(DW), .NWS_W(NWS_W)) uut (
    .clk(clk), .rst_n(rst_n), .boot_wide(boot_wide), .cfg_wr(cfg_wr),
    .cfg_early(cfg_early), .cfg_wse(cfg_wse), .cfg_nws(cfg_nws),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
    .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit wide);
    @(posedge clk); #2;
    rst_n = 1'b0; boot_wide = wide; req_valid = 1'b0; cfg_wr = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    m_early = 0; m_wse = 1; m_nws = 7; m_prevwr = 0; m_wide = wide;
  endtask

  task automatic set_cfg(input bit early, input bit wse, input int nws);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_early = early; cfg_wse = wse; cfg_nws = NWS_W'(nws);
    @(posedge clk); #2;
    cfg_wr = 1'b0;
    m_early = early; m_wse = wse; m_nws = nws; m_prevwr = 0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
    #2;
    m_prevwr = 0;
  endtask

  // Driver: caller is at posedge+2; the request is presented at once
  task automatic access(input bit wr, input logic [15:0] addr, input logic [15:0] wdata, input string tag);
    item_t it;
    int cyc;
    it.wr    = wr;
    it.turn  = m_early && m_prevwr && !wr;
    it.early = m_early;
    it.data  = wr ? lanes(wdata) : lanes(mem_model(addr));
    cyc      = (it.turn ? 1 : 0) + 1 + (m_wse ? m_nws + 1 : 0);
    it.ticks = 2 * cyc;
    it.tag   = tag;
    q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
    m_prevwr = wr;
  endtask

  // Monitor: pops the expected item at the first tick and follows every tick
  initial begin
    int cnt;
    int first;
    bit pend;
    logic [15:0] pexp;
    string ptag;
    item_t cur;
    cnt = 0; pend = 0; pexp = '0; ptag = "";
    cur.wr = 0; cur.turn = 0; cur.early = 0; cur.data = '0; cur.ticks = 0; cur.tag = "";
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cnt = 0; pend = 0;
        continue;
      end
      if (pend) begin
        // R10 read data captured at the end of the ready tick
        check(rsp_rdata == pexp, {ptag, " R10 rdata"}, 32'(rsp_rdata), 32'(pexp));
        pend = 0;
      end
      // R12 strobe exclusion and output enable
      if (!mem_rd_n && !mem_we_n)
        check(1'b0, "R12 both strobes low", 32'(0), 32'(1));
      if (mem_doe == mem_we_n)
        check(1'b0, "R12 doe mismatch", 32'(mem_doe), 32'(!mem_we_n));
      if (req_valid) begin
        cnt++;
        if (cnt == 1) begin
          if (q.size() == 0) check(1'b0, "scoreboard empty", 32'(0), 32'(1));
          else cur = q.pop_front();
        end
        first = cur.turn ? 3 : 1;
        if (cnt < first) begin
          // R6 turnaround cycle quiet
          check(mem_cs_n && mem_rd_n && mem_we_n, {cur.tag, " R6 turnaround pins"},
                32'({mem_cs_n, mem_rd_n, mem_we_n}), 32'h7);
        end else begin
          // R2 / R11 chip select low from the first access tick
          check(!mem_cs_n, {cur.tag, " R2 cs low"}, 32'(mem_cs_n), 32'(0));
          if (cnt == first) begin
            if (cur.wr)
              check(mem_we_n, {cur.tag, " R3 we high first half"}, 32'(mem_we_n), 32'(1));
            else
              check(mem_rd_n == !cur.early, {cur.tag, " R2/R4 rd first tick"},
                    32'(mem_rd_n), 32'(!cur.early));
          end else if (cur.wr) begin
            check(!mem_we_n && mem_doe && mem_dout == cur.data, {cur.tag, " R3 write strobe/data"},
                  32'({mem_we_n, mem_doe, mem_dout}), 32'({1'b0, 1'b1, cur.data}));
          end else begin
            check(!mem_rd_n, {cur.tag, " R2 rd low"}, 32'(mem_rd_n), 32'(0));
          end
        end
        if (req_ready) begin
          // R7 / R10 access length to the ready tick
          check(cnt == cur.ticks, {cur.tag, " length"}, 32'(cnt), 32'(cur.ticks));
          if (!cur.wr) begin pend = 1; pexp = cur.data; ptag = cur.tag; end
          cnt = 0;
        end
      end else if (req_ready) begin
        check(1'b0, "R10 ready without request", 32'(1), 32'(0));
      end
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    // R1 idle pins after reset
    check(mem_cs_n && mem_rd_n && mem_we_n && !mem_doe && !req_ready, "R1 reset pins",
          32'({mem_cs_n, mem_rd_n, mem_we_n, mem_doe, req_ready}), 32'b11100);
    @(posedge clk); #2;
    access(0, 16'h1234, 16'h0, "R1");          // default: 18 ticks, standard read
    access(1, 16'h2000, 16'hBEEF, "R3");       // default write
    idle(2);
    set_cfg(0, 0, 0);
    access(0, 16'h00A5, 16'h0, "R7");          // 2 ticks
    access(1, 16'h00A6, 16'hC0DE, "R11");      // write right after standard read
    access(0, 16'h00A7, 16'h0, "R11");         // standard: no turnaround after write
    idle(2);
    set_cfg(1, 1, 1);
    access(0, 16'h4321, 16'h0, "R4");          // early: rd low at once, 6 ticks
    access(0, 16'h4322, 16'h0, "R5");          // back to back: continuous rd
    access(1, 16'h4400, 16'h1357, "R3");
    access(0, 16'h4401, 16'h0, "R6");          // turnaround + waits: 8 ticks
    idle(2);
    set_cfg(1, 0, 0);
    access(1, 16'h5000, 16'h2468, "R3");
    access(0, 16'h5001, 16'h0, "R6");          // turnaround without waits: 4 ticks
    idle(3);
    access(0, 16'h5002, 16'h0, "R6");          // idle gap: no turnaround
    idle(2);
    set_cfg(0, 1, 3);
    access(0, 16'h6006, 16'h0, "R8");          // new count applies: 10 ticks
    idle(2);
    do_reset(1'b0);
    @(posedge clk); #2;
    access(0, 16'h7788, 16'h0, "R9");          // narrow, default 18 ticks
    access(1, 16'h7789, 16'hA1B2, "R9");       // narrow write
    idle(4);
    check(q.size() == 0, "R10 all accesses completed", 32'(q.size()), 32'(0));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule